// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Retry Scheduler

This block decides when a half-duplex Ethernet MAC may put a pending frame on the wire, and when it may try again after a collision. While a frame waits, the block watches carrier sense. It starts the frame only after the medium has been quiet for one interframe gap. It also times how long the frame has been held off by a busy carrier, and drops the frame when that time passes a limit. The limit depends on the selected line rate.

After a collision the block bumps a retry counter and schedules the next attempt. By default the wait is a truncated binary exponential backoff, counted in slot-time ticks and drawn from a free-running LFSR. Two configuration inputs change this behaviour. One lets the frame defer to carrier for as long as needed. The other skips the backoff wait, so the frame goes straight back into deferral. A frame that collides sixteen times is dropped with its own cause code.

Time is counted in clock cycles. Each cycle is one nibble time when the fast rate is selected and one bit time when the slow rate is selected. The MAC holds the request high for the whole frame and lowers it when the frame has gone out.

Top module: `eth_defer_backoff`

## Requirements
- R1: During reset and on the first cycle after it, `tx_start` and `abort` are 0, `abort_cause` is 0 and `retry_count` is 0.
- R2: Once a frame is requested, `tx_start` pulses for exactly one cycle after carrier has been idle for the gap: 24 cycles when `speed_fast`=1, 96 cycles when `speed_fast`=0. With carrier idle from the request on, the pulse is visible after the 25th (or 97th) rising edge that follows the request.
- R3: With `speed_fast`=1 and `defer_forever`=0, a frame that sees carrier busy for 6071 consecutive cycles is dropped. `abort` pulses after the 6071st busy edge of the deferral with `abort_cause`=2'b01.
- R4: With `speed_fast`=0 and `defer_forever`=0, the same drop happens after 24287 consecutive busy cycles, again with cause 2'b01.
- R5: The deferral time restarts from zero whenever carrier goes idle. A later busy stretch needs the full limit again before a drop.
- R6: While `defer_forever`=1, no deferral drop happens however long the carrier stays busy. The frame starts one gap after carrier falls.
- R7: Each collision while transmitting raises `retry_count` by one. With `skip_backoff`=0 the frame then waits W slot ticks before it defers again. Here W = L & (2^k−1), where k = min(retry_count, 10) and L is the LFSR value. The LFSR is 16 bits wide, seeded with 16'hACE1 at reset, and shifts left every cycle with feedback bit0 = b15^b13^b12^b10. The collision uses the value the LFSR holds on the edge where the collision is sampled.
- R8: With `skip_backoff`=1, a collision sends the frame straight back into deferral. It starts again one gap later without any slot tick.
- R9: The 16th collision of a frame drops it. `abort` pulses with `abort_cause`=2'b10, `retry_count` returns to 0, and the drop takes priority over an immediate retry.
- R10: Lowering `tx_req` during a transmission with no collision ends the frame successfully. `retry_count` returns to 0 and there is no abort.
- R11: A collision sampled in the same cycle that `tx_req` falls counts as a collision, not as a successful end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one nibble or bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Frame pending; held high until the frame ends |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision seen during the transmission |
| speed_fast | input | 1 | 1 = fast rate (nibble units), 0 = slow rate (bit units) |
| defer_forever | input | 1 | 1 = never drop on excessive deferral |
| skip_backoff | input | 1 | 1 = retry without a backoff wait |
| slot_tick | input | 1 | One-cycle pulse per slot time |
| tx_start | output | 1 | One-cycle pulse: begin transmission |
| abort | output | 1 | One-cycle pulse: frame dropped |
| abort_cause | output | 2 | 01 excessive deferral, 10 excessive collisions, 00 otherwise |
| retry_count | output | 4 | Collisions so far for the current frame |

## Verification
The two functions that can meet in one cycle are ending a frame successfully and counting a collision. The bench lowers the request on the same cycle that it drives the sixteenth collision, with the no-backoff bit set. The result is judged correct only if the drop pulse shows the collision cause and the counter clears. No further start may appear in the cycles that follow. This shows that collision handling and the drop outrank both a successful end and an immediate retry.

// File: rtl/edb_pkg.sv
`timescale 1ns/1ps
package edb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_DEFER   = 2'd1,
      ST_XMIT    = 2'd2,
      ST_BACKOFF = 2'd3
   } edb_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_DEFER = 2'd1,
      CAUSE_COLL  = 2'd2
   } edb_cause_e;

   function automatic int edb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/edb_lfsr.sv
`timescale 1ns/1ps
module edb_lfsr #(
   parameter int              W    = 16,
   parameter int              OW   = 10,
   parameter logic [W-1:0]    SEED = 'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [OW-1:0] rnd
);
   logic [W-1:0] q;
   logic         fb;

   generate
      if (W == 16) begin : g_w16
         assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
      end else if (W == 32) begin : g_w32
         assign fb = q[31] ^ q[21] ^ q[1] ^ q[0];
      end else begin : g_bad_w
         $error("edb_lfsr: unsupported width");
         assign fb = 1'b0;
      end
      if (OW > W) begin : g_bad_ow
         $error("edb_lfsr: output wider than register");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end

   assign rnd = q[OW-1:0];

   // R7: the random source never locks up at zero
   assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
endmodule

// File: rtl/edb_defer_timer.sv
`timescale 1ns/1ps
module edb_defer_timer #(
   parameter int LIMIT_FAST = 6071,
   parameter int LIMIT_SLOW = 24287,
   parameter int GAP_FAST   = 24,
   parameter int GAP_SLOW   = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic crs,
   input  logic fast,
   input  logic no_limit,
   output logic limit_hit,
   output logic gap_done
);
   import edb_pkg::*;
   localparam int LIM_MAX = edb_max(LIMIT_FAST, LIMIT_SLOW);
   localparam int GAP_MAX = edb_max(GAP_FAST, GAP_SLOW);
   localparam int CW      = $clog2(LIM_MAX + 1);
   localparam int GW      = $clog2(GAP_MAX + 1);

   generate
      if (LIMIT_FAST < 2 || LIMIT_SLOW < 2) begin : g_bad_lim
         $error("edb_defer_timer: limits must be at least 2");
      end
      if (GAP_FAST < 2 || GAP_SLOW < 2) begin : g_bad_gap
         $error("edb_defer_timer: gaps must be at least 2");
      end
   endgenerate

   logic [CW-1:0] busy_cnt, lim_m1;
   logic [GW-1:0] idle_cnt, gap_m1;

   assign lim_m1 = fast ? CW'(LIMIT_FAST - 1) : CW'(LIMIT_SLOW - 1);
   assign gap_m1 = fast ? GW'(GAP_FAST - 1)   : GW'(GAP_SLOW - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         idle_cnt <= '0;
      end else if (!active) begin
         busy_cnt <= '0;
         idle_cnt <= '0;
      end else if (crs) begin
         idle_cnt <= '0;
         if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
      end else begin
         busy_cnt <= '0;
         if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign limit_hit = active && crs && !no_limit && (busy_cnt == lim_m1);
   assign gap_done  = active && !crs && (idle_cnt == gap_m1);

   // R2: a start decision always follows an idle carrier cycle
   assert_gap_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gap_done |-> !$past(crs));
   // R5: a deferral drop is only reached through an unbroken busy stretch
   assert_limit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |-> ($past(crs) && $past(active)));
endmodule

// File: rtl/edb_backoff.sv
`timescale 1ns/1ps
module edb_backoff #(
   parameter int SW = 10,
   parameter int NW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [NW-1:0] attempt,
   input  logic [SW-1:0] rnd,
   input  logic          active,
   input  logic          tick,
   output logic          done
);
   logic [SW-1:0] mask;
   logic [SW-1:0] slots;

   generate
      for (genvar i = 0; i < SW; i++) begin : g_mask
         assign mask[i] = (attempt > NW'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slots <= '0;
      else if (load)                             slots <= rnd & mask;
      else if (active && tick && slots != '0)    slots <= slots - 1'b1;
   end

   assign done = active && ((slots == '0) || (tick && slots == SW'(1)));

   // R7: the wait only shrinks on a slot tick
   assert_slots_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> (slots == $past(slots)));
endmodule

// File: rtl/eth_defer_backoff.sv
`timescale 1ns/1ps
module eth_defer_backoff #(
   parameter int                 LIMIT_FAST   = 6071,
   parameter int                 LIMIT_SLOW   = 24287,
   parameter int                 GAP_FAST     = 24,
   parameter int                 GAP_SLOW     = 96,
   parameter int                 MAX_ATTEMPTS = 16,
   parameter int                 BO_LIMIT     = 10,
   parameter int                 LFSR_W       = 16,
   parameter logic [LFSR_W-1:0]  LFSR_SEED    = 'hACE1,
   localparam int                RW           = $clog2(MAX_ATTEMPTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_req,
   input  logic          carrier_sense,
   input  logic          collision,
   input  logic          speed_fast,
   input  logic          defer_forever,
   input  logic          skip_backoff,
   input  logic          slot_tick,
   output logic          tx_start,
   output logic          abort,
   output logic [1:0]    abort_cause,
   output logic [RW-1:0] retry_count
);
   import edb_pkg::*;
   localparam int NW = RW + 1;

   generate
      if (MAX_ATTEMPTS < 2) begin : g_bad_att
         $error("eth_defer_backoff: MAX_ATTEMPTS below 2");
      end
      if (BO_LIMIT > LFSR_W || BO_LIMIT < 1) begin : g_bad_bo
         $error("eth_defer_backoff: BO_LIMIT out of range");
      end
      if (LFSR_SEED == '0) begin : g_bad_seed
         $error("eth_defer_backoff: LFSR seed must be non-zero");
      end
   endgenerate

   edb_state_e     st;
   logic [NW-1:0]  attempt_nxt;
   logic           limit_hit, gap_done, bo_done, bo_load, last_try;
   logic [BO_LIMIT-1:0] rnd;

   assign attempt_nxt = {1'b0, retry_count} + 1'b1;
   assign last_try    = (attempt_nxt == NW'(MAX_ATTEMPTS));
   assign bo_load     = (st == ST_XMIT) && collision && !last_try && !skip_backoff;

   edb_lfsr #(.W(LFSR_W), .OW(BO_LIMIT), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .rnd(rnd)
   );

   edb_defer_timer #(
      .LIMIT_FAST(LIMIT_FAST), .LIMIT_SLOW(LIMIT_SLOW),
      .GAP_FAST(GAP_FAST),     .GAP_SLOW(GAP_SLOW)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .active(st == ST_DEFER),
      .crs(carrier_sense), .fast(speed_fast), .no_limit(defer_forever),
      .limit_hit(limit_hit), .gap_done(gap_done)
   );

   edb_backoff #(.SW(BO_LIMIT), .NW(NW)) u_backoff (
      .clk(clk), .rst_n(rst_n), .load(bo_load), .attempt(attempt_nxt),
      .rnd(rnd), .active(st == ST_BACKOFF), .tick(slot_tick), .done(bo_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         retry_count <= '0;
         tx_start    <= 1'b0;
         abort       <= 1'b0;
         abort_cause <= CAUSE_NONE;
      end else begin
         tx_start    <= 1'b0;
         abort       <= 1'b0;
         abort_cause <= CAUSE_NONE;
         case (st)
            ST_IDLE: begin
               if (tx_req) st <= ST_DEFER;
            end
            ST_DEFER: begin
               if (limit_hit) begin
                  st          <= ST_IDLE;
                  abort       <= 1'b1;
                  abort_cause <= CAUSE_DEFER;
                  retry_count <= '0;
               end else if (gap_done) begin
                  st       <= ST_XMIT;
                  tx_start <= 1'b1;
               end
            end
            ST_XMIT: begin
               if (collision) begin
                  if (last_try) begin
                     st          <= ST_IDLE;
                     abort       <= 1'b1;
                     abort_cause <= CAUSE_COLL;
                     retry_count <= '0;
                  end else begin
                     retry_count <= attempt_nxt[RW-1:0];
                     st          <= skip_backoff ? ST_DEFER : ST_BACKOFF;
                  end
               end else if (!tx_req) begin
                  st          <= ST_IDLE;
                  retry_count <= '0;
               end
            end
            ST_BACKOFF: begin
               if (bo_done) st <= ST_DEFER;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2: the start indication is a single-cycle pulse
   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
   // R9: a cause accompanies every drop and only a drop
   assert_cause_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (abort_cause == CAUSE_DEFER || abort_cause == CAUSE_COLL));
   assert_cause_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !abort |-> (abort_cause == CAUSE_NONE));
   // R6: no deferral drop while indefinite deferral was enabled
   assert_no_defer_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && abort_cause == CAUSE_DEFER) |-> !$past(defer_forever));
   // R7: the retry count moves by one or clears
   assert_retry_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_count != $past(retry_count)) |->
      (retry_count == $past(retry_count) + 1'b1 || retry_count == '0));
endmodule

// File: tb/eth_defer_backoff_bench.sv
`timescale 1ns/1ps
module eth_defer_backoff_bench;
   localparam int LIM_F = 6071;
   localparam int LIM_S = 24287;
   localparam int GAP_F = 24;
   localparam int GAP_S = 96;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_req = 0, carrier_sense = 0, collision = 0, speed_fast = 1;
   logic defer_forever = 0, skip_backoff = 0, slot_tick = 0;
   logic tx_start, abort;
   logic [1:0] abort_cause;
   logic [3:0] retry_count;
   logic [15:0] mdl;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   eth_defer_backoff u_eth_defer_backoff (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .carrier_sense(carrier_sense),
      .collision(collision), .speed_fast(speed_fast), .defer_forever(defer_forever),
      .skip_backoff(skip_backoff), .slot_tick(slot_tick), .tx_start(tx_start),
      .abort(abort), .abort_cause(abort_cause), .retry_count(retry_count)
   );

   // LFSR model from the requirement (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdl <= 16'hACE1;
      else        mdl <= {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_start(input int bound, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tx_start && n < bound);
   endtask

   task automatic test_reset();
      chk(!tx_start && !abort, "R1 outputs in reset", {tx_start, abort}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!tx_start && !abort && abort_cause == 0, "R1 pulses after reset", {tx_start, abort, abort_cause}, 0);
      chk(retry_count == 0, "R1 retry count", retry_count, 0);
   endtask

   task automatic test_start_gap(input bit fast, input int gap);
      bit early = 0;
      speed_fast = fast; tx_req = 1; carrier_sense = 0;
      for (int i = 1; i <= gap; i++) begin
         @(negedge clk);
         if (tx_start) early = 1;
      end
      chk(!early, "R2 no early start", early, 0);
      @(negedge clk);
      chk(tx_start, "R2 start after gap", tx_start, 1);
      @(negedge clk);
      chk(!tx_start, "R2 start is one cycle", tx_start, 0);
      tx_req = 0;
      @(negedge clk); @(negedge clk);
      chk(retry_count == 0 && !abort, "R10 clean end", {abort, retry_count}, 0);
   endtask

   task automatic test_limit(input bit fast, input int lim, input string tag);
      bit early = 0;
      speed_fast = fast; tx_req = 1; carrier_sense = 1;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (abort || tx_start) early = 1;
      end
      chk(!early, {tag, " no early drop"}, early, 0);
      @(negedge clk);
      chk(abort && abort_cause == 2'b01, {tag, " deferral drop"}, {abort, abort_cause}, 5);
      tx_req = 0; carrier_sense = 0;
      @(negedge clk);
      chk(!abort, {tag, " drop is one cycle"}, abort, 0);
   endtask

   task automatic test_restart();
      bit early = 0;
      speed_fast = 1; tx_req = 1; carrier_sense = 1;
      repeat (5000) begin
         @(negedge clk);
         if (abort) early = 1;
      end
      carrier_sense = 0;
      repeat (3) @(negedge clk);
      carrier_sense = 1;
      for (int i = 1; i < LIM_F; i++) begin
         @(negedge clk);
         if (abort || tx_start) early = 1;
      end
      chk(!early, "R5 count restarted on idle", early, 0);
      @(negedge clk);
      chk(abort && abort_cause == 2'b01, "R5 drop after full limit", {abort, abort_cause}, 5);
      tx_req = 0; carrier_sense = 0;
      @(negedge clk);
   endtask

   task automatic test_forever();
      bit dropped = 0;
      int n;
      speed_fast = 1; defer_forever = 1; tx_req = 1; carrier_sense = 1;
      repeat (10000) begin
         @(negedge clk);
         if (abort) dropped = 1;
      end
      chk(!dropped, "R6 no drop while deferring forever", dropped, 0);
      carrier_sense = 0;
      wait_start(GAP_F + 3, n);
      chk(tx_start, "R6 start once carrier drops", n, GAP_F);
      tx_req = 0; defer_forever = 0;
      @(negedge clk); @(negedge clk);
   endtask

   // caller is at a negedge with the design transmitting
   task automatic backoff_round(input int n);
      int k, expv, cnt, m;
      bit found = 0;
      k = (n < 10) ? n : 10;
      expv = int'(mdl) & ((1 << k) - 1);
      collision = 1;
      @(negedge clk);
      collision = 0;
      chk(retry_count == n[3:0], "R7 retry count step", retry_count, n);
      cnt = 0;
      for (int cyc = 1; cyc <= 30 * 1030; cyc++) begin
         @(negedge clk);
         if (tx_start) begin
            found = 1;
            slot_tick = 0;
            break;
         end
         slot_tick = (cyc % 30 == 0);
         if (slot_tick) cnt++;
      end
      m = found ? cnt : -1;
      chk(found && cnt == expv, "R7 backoff slot count", m, expv);
   endtask

   task automatic immediate_round(input int n);
      int w;
      collision = 1;
      @(negedge clk);
      collision = 0;
      chk(retry_count == n[3:0], "R8 retry count step", retry_count, n);
      wait_start(GAP_F + 3, w);
      chk(tx_start, "R8 immediate retry", w, GAP_F);
   endtask

   task automatic test_backoff();
      int n;
      speed_fast = 1; skip_backoff = 0; tx_req = 1; carrier_sense = 0;
      wait_start(GAP_F + 3, n);
      chk(tx_start, "R7 first start", n, GAP_F + 1);
      for (int r = 1; r <= 3; r++) backoff_round(r);
      tx_req = 0;
      @(negedge clk);
      chk(retry_count == 0 && !abort, "R10 success clears retry", retry_count, 0);
   endtask

   task automatic test_coll_limit();
      int n;
      bit stray = 0;
      speed_fast = 1; skip_backoff = 1; tx_req = 1; carrier_sense = 0;
      wait_start(GAP_F + 3, n);
      for (int r = 1; r <= 15; r++) immediate_round(r);
      collision = 1; tx_req = 0;      // R11: collision and end in one cycle
      @(negedge clk);
      collision = 0;
      chk(abort && abort_cause == 2'b10, "R9 R11 collision drop", {abort, abort_cause}, 6);
      chk(retry_count == 0, "R9 retry cleared", retry_count, 0);
      repeat (50) begin
         @(negedge clk);
         if (tx_start || abort) stray = 1;
      end
      chk(!stray, "R9 no retry after drop", stray, 0);
      skip_backoff = 0;
   endtask

   task automatic test_truncation();
      int n;
      speed_fast = 1; skip_backoff = 1; tx_req = 1; carrier_sense = 0;
      wait_start(GAP_F + 3, n);
      for (int r = 1; r <= 10; r++) immediate_round(r);
      skip_backoff = 0;
      backoff_round(11);
      backoff_round(12);
      tx_req = 0;
      @(negedge clk);
      chk(retry_count == 0, "R10 clear after long retry", retry_count, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      test_reset();
      test_start_gap(1'b1, GAP_F);
      test_start_gap(1'b0, GAP_S);
      test_limit(1'b1, LIM_F, "R3");
      test_restart();
      test_limit(1'b0, LIM_S, "R4");
      test_forever();
      test_backoff();
      test_coll_limit();
      test_truncation();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule